// File: doc/BRIEF.md
# Register File with Indirect Addressing

This block is the 8-bit data register file of a small microcontroller core. A 5-bit address reaches 31 usable locations. The low addresses are special: a timer/counter byte, the low byte of the program counter, a status byte, a pointer byte used for indirection, and the data bytes of three ports. Everything above them is general-purpose storage. Writes happen on the rising clock edge through an address/data/enable port. Reads are combinational from a separate read address.

Address 00h has no storage behind it. Any read or write that names it is redirected to the location given by the low five bits of the pointer byte at 04h. The pointer byte lives in the same file, so it can itself be reached indirectly. A pointer that selects 00h again yields a null location: it reads as zero and swallows writes. The logic that owns the timer, program counter, status and port bytes updates them through load hooks. In any cycle where the bus also writes the same byte, the bus write wins. A build-time option removes port C and turns 07h into ordinary storage.

Top module: `mcu_regfile`

## Requirements
- R1: A bus write to any general-purpose address (08h to 1Fh) is returned by a read of that address from the cycle after the write edge. Until then, reads return the old value.
- R2: A read or write at address 00h acts on the location given by bits 4:0 of the pointer byte (`ptr_q`, address 04h). Bits 7:5 of the pointer have no effect on the location chosen.
- R3: When pointer bits 4:0 are zero, a read at 00h returns 8'h00 and a write at 00h changes no location.
- R4: Addresses 01h, 02h, 03h, 04h, 05h, 06h and 07h read back `tmr_q`, `pcl_q`, `stat_q`, `ptr_q` and the port A, B and C bytes. The port bytes are `prt_q[7:0]`, `prt_q[15:8]` and `prt_q[23:16]`.
- R5: A bus write to 02h, direct or indirect, appears on `pcl_q` one cycle after the write edge, so the program counter logic can branch on it.
- R6: If the bus writes the timer, program counter, status or a port byte in the same cycle that its owner load hook is active, the bus data is what gets stored.
- R7: Status bits 4 and 3 cannot be changed by the bus. On a bus write to 03h they keep their old value, or take `stat_upd_val` if `stat_upd_en` is high in that cycle. Bits 7:5 and 2:0 take the bus data.
- R8: A synchronous active-high reset clears every byte to 8'h00, except the status byte, which becomes 8'h18.
- R9: With `HAS_PORTC` = 0, address 07h is ordinary storage, `prt_q[23:16]` stays 8'h00, and `prt_ld_en[2]` has no effect.
- R10: An owner load hook with no bus write to its byte stores its value at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write enable |
| wr_addr | input | 5 | Bus write address (00h means indirect) |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | 5 | Read address (00h means indirect) |
| rd_data | output | 8 | Combinational read data |
| tmr_upd_en | input | 1 | Timer owner load enable |
| tmr_upd_val | input | 8 | Timer owner load value |
| tmr_q | output | 8 | Timer/counter byte |
| pcl_upd_en | input | 1 | Program counter owner load enable |
| pcl_upd_val | input | 8 | Program counter owner load value |
| pcl_q | output | 8 | Program counter low byte |
| stat_upd_en | input | 1 | Status owner load enable |
| stat_upd_val | input | 8 | Status owner load value |
| stat_q | output | 8 | Status byte |
| ptr_q | output | 8 | Pointer byte used for indirection |
| prt_ld_en | input | 3 | Port owner load enables, bit i for port i |
| prt_ld_val | input | 24 | Port owner load values, 8 bits per port |
| prt_q | output | 24 | Port data bytes, port A in bits 7:0 |

## Verification
Every stored byte, including the pointer, changes exactly one clock edge after its write or load. The read data has no register in its path: it changes in the same cycle as the read address and as the stored byte it selects. For that reason the bench drives inputs on the falling edge and compares the read port and all register outputs shortly after. It then lets the rising edge commit the step and advances its reference model only after that edge, so each check sees the state left by the previous edge. Indirect checks use the pointer value from before the current edge. A pointer rewrite is therefore only visible to the following access.

// File: rtl/rfile_pkg.sv
package rfile_pkg;

    localparam int RF_DW = 8;
    localparam int RF_AW = 5;
    localparam int RF_NPORT = 3;

    typedef enum logic [4:0] {
        SA_NULL = 5'd0,
        SA_TMR  = 5'd1,
        SA_PCL  = 5'd2,
        SA_STAT = 5'd3,
        SA_PTR  = 5'd4,
        SA_PRTA = 5'd5,
        SA_PRTB = 5'd6,
        SA_PRTC = 5'd7
    } sfr_addr_e;

    localparam logic [7:0] STAT_RST_VAL = 8'h18;
    localparam logic [7:0] STAT_RO_MASK = 8'h18;

endpackage

// File: rtl/rf_addr_xlate.sv
module rf_addr_xlate #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [ADDR_W-1:0] ptr_low,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              is_null
);
    logic [ADDR_W-1:0] sel;

    always_comb begin
        sel = (raw_addr == '0) ? ptr_low : raw_addr;
        eff_addr = sel;
        is_null  = (sel == '0);
    end
endmodule

// File: rtl/rf_gp_store.sv
module rf_gp_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int LO_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (int'(waddr) >= LO_ADDR)) begin
            mem_d[waddr] = wdata;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            if (g < LO_ADDR) begin : g_unused
                always_ff @(posedge clk) begin
                    mem_q[g] <= '0;
                end
            end else begin : g_store
                always_ff @(posedge clk) begin
                    if (rst) begin
                        mem_q[g] <= '0;
                    end else begin
                        mem_q[g] <= mem_d[g];
                    end
                end
            end
        end
    endgenerate

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rf_sfr_bank.sv
module rf_sfr_bank
    import rfile_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int NPORT = 3,
    parameter bit HAS_PORTC = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     tmr_upd_en,
    input  logic [DATA_W-1:0]        tmr_upd_val,
    input  logic                     pcl_upd_en,
    input  logic [DATA_W-1:0]        pcl_upd_val,
    input  logic                     stat_upd_en,
    input  logic [DATA_W-1:0]        stat_upd_val,
    input  logic [NPORT-1:0]         prt_ld_en,
    input  logic [NPORT*DATA_W-1:0]  prt_ld_val,
    output logic [DATA_W-1:0]        tmr_q,
    output logic [DATA_W-1:0]        pcl_q,
    output logic [DATA_W-1:0]        stat_q,
    output logic [DATA_W-1:0]        ptr_q,
    output logic [NPORT*DATA_W-1:0]  prt_q
);
    localparam int NPORT_ACT = HAS_PORTC ? NPORT : NPORT - 1;
    localparam logic [DATA_W-1:0] RO_MASK = DATA_W'(STAT_RO_MASK);
    localparam logic [DATA_W-1:0] ST_RST  = DATA_W'(STAT_RST_VAL);

    typedef struct packed {
        logic [DATA_W-1:0]             tmr;
        logic [DATA_W-1:0]             pcl;
        logic [DATA_W-1:0]             stat;
        logic [DATA_W-1:0]             ptr;
        logic [NPORT-1:0][DATA_W-1:0]  prt;
    } sfr_state_t;

    sfr_state_t st_d, st_q;
    logic [DATA_W-1:0] stat_ro_src;

    always_comb begin
        st_d = st_q;
        stat_ro_src = stat_upd_en ? stat_upd_val : st_q.stat;

        if (we && waddr == ADDR_W'(SA_TMR)) begin
            st_d.tmr = wdata;
        end else if (tmr_upd_en) begin
            st_d.tmr = tmr_upd_val;
        end

        if (we && waddr == ADDR_W'(SA_PCL)) begin
            st_d.pcl = wdata;
        end else if (pcl_upd_en) begin
            st_d.pcl = pcl_upd_val;
        end

        if (we && waddr == ADDR_W'(SA_STAT)) begin
            st_d.stat = (wdata & ~RO_MASK) | (stat_ro_src & RO_MASK);
        end else if (stat_upd_en) begin
            st_d.stat = stat_upd_val;
        end

        if (we && waddr == ADDR_W'(SA_PTR)) begin
            st_d.ptr = wdata;
        end

        for (int i = 0; i < NPORT; i++) begin
            if (i < NPORT_ACT) begin
                if (we && waddr == ADDR_W'(int'(SA_PRTA) + i)) begin
                    st_d.prt[i] = wdata;
                end else if (prt_ld_en[i]) begin
                    st_d.prt[i] = prt_ld_val[i*DATA_W +: DATA_W];
                end
            end else begin
                st_d.prt[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.stat <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_q  = st_q.tmr;
    assign pcl_q  = st_q.pcl;
    assign stat_q = st_q.stat;
    assign ptr_q  = st_q.ptr;
    assign prt_q  = st_q.prt;
endmodule

// File: rtl/mcu_regfile.sv
module mcu_regfile
    import rfile_pkg::*;
#(
    parameter int DATA_W = RF_DW,
    parameter int ADDR_W = RF_AW,
    parameter int NPORT = RF_NPORT,
    parameter bit HAS_PORTC = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    tmr_upd_en,
    input  logic [DATA_W-1:0]       tmr_upd_val,
    output logic [DATA_W-1:0]       tmr_q,
    input  logic                    pcl_upd_en,
    input  logic [DATA_W-1:0]       pcl_upd_val,
    output logic [DATA_W-1:0]       pcl_q,
    input  logic                    stat_upd_en,
    input  logic [DATA_W-1:0]       stat_upd_val,
    output logic [DATA_W-1:0]       stat_q,
    output logic [DATA_W-1:0]       ptr_q,
    input  logic [NPORT-1:0]        prt_ld_en,
    input  logic [NPORT*DATA_W-1:0] prt_ld_val,
    output logic [NPORT*DATA_W-1:0] prt_q
);
    localparam int GP_LO = HAS_PORTC ? int'(SA_PRTA) + NPORT : int'(SA_PRTA) + NPORT - 1;

    logic [ADDR_W-1:0] w_eff, r_eff;
    logic              w_null, r_null;
    logic              w_gp, w_sfr;
    logic [DATA_W-1:0] gp_rdata;

    rf_addr_xlate #(.ADDR_W(ADDR_W)) u_wx (
        .raw_addr (wr_addr),
        .ptr_low  (ptr_q[ADDR_W-1:0]),
        .eff_addr (w_eff),
        .is_null  (w_null)
    );

    rf_addr_xlate #(.ADDR_W(ADDR_W)) u_rx (
        .raw_addr (rd_addr),
        .ptr_low  (ptr_q[ADDR_W-1:0]),
        .eff_addr (r_eff),
        .is_null  (r_null)
    );

    always_comb begin
        w_gp  = wr_en && !w_null && (int'(w_eff) >= GP_LO);
        w_sfr = wr_en && !w_null && (int'(w_eff) <  GP_LO);
    end

    rf_sfr_bank #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NPORT     (NPORT),
        .HAS_PORTC (HAS_PORTC)
    ) u_sfr (
        .clk          (clk),
        .rst          (rst),
        .we           (w_sfr),
        .waddr        (w_eff),
        .wdata        (wr_data),
        .tmr_upd_en   (tmr_upd_en),
        .tmr_upd_val  (tmr_upd_val),
        .pcl_upd_en   (pcl_upd_en),
        .pcl_upd_val  (pcl_upd_val),
        .stat_upd_en  (stat_upd_en),
        .stat_upd_val (stat_upd_val),
        .prt_ld_en    (prt_ld_en),
        .prt_ld_val   (prt_ld_val),
        .tmr_q        (tmr_q),
        .pcl_q        (pcl_q),
        .stat_q       (stat_q),
        .ptr_q        (ptr_q),
        .prt_q        (prt_q)
    );

    rf_gp_store #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .LO_ADDR (GP_LO)
    ) u_gp (
        .clk   (clk),
        .rst   (rst),
        .we    (w_gp),
        .waddr (w_eff),
        .wdata (wr_data),
        .raddr (r_eff),
        .rdata (gp_rdata)
    );

    always_comb begin
        rd_data = gp_rdata;
        if (r_null) begin
            rd_data = '0;
        end else if (int'(r_eff) < GP_LO) begin
            unique case (r_eff)
                ADDR_W'(SA_TMR):  rd_data = tmr_q;
                ADDR_W'(SA_PCL):  rd_data = pcl_q;
                ADDR_W'(SA_STAT): rd_data = stat_q;
                ADDR_W'(SA_PTR):  rd_data = ptr_q;
                default:          rd_data = prt_q[(int'(r_eff) - int'(SA_PRTA))*DATA_W +: DATA_W];
            endcase
        end
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rfile_pkg::*;
#(
    parameter int DATA_W = RF_DW,
    parameter int ADDR_W = RF_AW
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              tmr_upd_en,
    input logic              stat_upd_en,
    input logic [DATA_W-1:0] tmr_q,
    input logic [DATA_W-1:0] pcl_q,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] ptr_q
);
    localparam logic [DATA_W-1:0] RO_M = DATA_W'(STAT_RO_MASK);
    logic [ADDR_W-1:0] chk_weff;
    assign chk_weff = (wr_addr == '0) ? ptr_q[ADDR_W-1:0] : wr_addr;

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (tmr_q == '0 && pcl_q == '0 && ptr_q == '0 && stat_q == DATA_W'(STAT_RST_VAL))); // R8

    AST_NULL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0 && ptr_q[ADDR_W-1:0] == '0) |-> rd_data == '0); // R3

    AST_NULL_WRITE_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0 && ptr_q[ADDR_W-1:0] == '0) |=> $stable(ptr_q)); // R3

    AST_PCL_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && chk_weff == ADDR_W'(SA_PCL)) |=> pcl_q == $past(wr_data)); // R5

    AST_TMR_BUS_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && chk_weff == ADDR_W'(SA_TMR) && tmr_upd_en) |=> tmr_q == $past(wr_data)); // R6

    AST_STAT_RO_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && chk_weff == ADDR_W'(SA_STAT) && !stat_upd_en)
        |=> (stat_q & RO_M) == ($past(stat_q) & RO_M)); // R7

    AST_PTR_READBACK: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(SA_PTR)) |-> rd_data == ptr_q); // R4
endmodule

bind mcu_regfile rf_checker u_rf_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .tmr_upd_en  (tmr_upd_en),
    .stat_upd_en (stat_upd_en),
    .tmr_q       (tmr_q),
    .pcl_q       (pcl_q),
    .stat_q      (stat_q),
    .ptr_q       (ptr_q)
);

// File: tb/tb_mcu_regfile.sv
module tb_mcu_regfile;
    logic clk = 1'b0;
    logic rst;
    logic wr_en;
    logic [4:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data, rd_data_nc;
    logic tmr_upd_en, pcl_upd_en, stat_upd_en;
    logic [7:0] tmr_upd_val, pcl_upd_val, stat_upd_val;
    logic [7:0] tmr_q, pcl_q, stat_q, ptr_q;
    logic [7:0] tmr_q_nc, pcl_q_nc, stat_q_nc, ptr_q_nc;
    logic [2:0] prt_ld_en;
    logic [23:0] prt_ld_val, prt_q, prt_q_nc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_gp [32];
    logic [7:0] m_tmr, m_pcl, m_st, m_ptr;
    logic [7:0] m_prt [3];

    always #10 clk = ~clk;

    mcu_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_upd_en(tmr_upd_en), .tmr_upd_val(tmr_upd_val), .tmr_q(tmr_q),
        .pcl_upd_en(pcl_upd_en), .pcl_upd_val(pcl_upd_val), .pcl_q(pcl_q),
        .stat_upd_en(stat_upd_en), .stat_upd_val(stat_upd_val), .stat_q(stat_q),
        .ptr_q(ptr_q), .prt_ld_en(prt_ld_en), .prt_ld_val(prt_ld_val), .prt_q(prt_q)
    );

    mcu_regfile #(.HAS_PORTC(1'b0)) dut_nc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_nc),
        .tmr_upd_en(tmr_upd_en), .tmr_upd_val(tmr_upd_val), .tmr_q(tmr_q_nc),
        .pcl_upd_en(pcl_upd_en), .pcl_upd_val(pcl_upd_val), .pcl_q(pcl_q_nc),
        .stat_upd_en(stat_upd_en), .stat_upd_val(stat_upd_val), .stat_q(stat_q_nc),
        .ptr_q(ptr_q_nc), .prt_ld_en(prt_ld_en), .prt_ld_val(prt_ld_val), .prt_q(prt_q_nc)
    );

    function automatic logic [4:0] m_eff(input logic [4:0] a);
        return (a == 5'd0) ? m_ptr[4:0] : a;
    endfunction

    function automatic logic [7:0] m_read(input logic [4:0] a);
        logic [4:0] e;
        e = m_eff(a);
        case (e)
            5'd0: return 8'h00;
            5'd1: return m_tmr;
            5'd2: return m_pcl;
            5'd3: return m_st;
            5'd4: return m_ptr;
            5'd5: return m_prt[0];
            5'd6: return m_prt[1];
            5'd7: return m_prt[2];
            default: return m_gp[e];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 32; i++) m_gp[i] = 8'h00;
        m_tmr = 8'h00; m_pcl = 8'h00; m_st = 8'h18; m_ptr = 8'h00;
        for (int i = 0; i < 3; i++) m_prt[i] = 8'h00;
    endtask

    task automatic m_commit();
        logic [4:0] e;
        logic wb;
        e  = m_eff(wr_addr);
        wb = wr_en && (e != 5'd0);
        if (wb && e == 5'd1) m_tmr = wr_data; else if (tmr_upd_en) m_tmr = tmr_upd_val;
        if (wb && e == 5'd2) m_pcl = wr_data; else if (pcl_upd_en) m_pcl = pcl_upd_val;
        if (wb && e == 5'd3)
            m_st = (wr_data & 8'hE7) | ((stat_upd_en ? stat_upd_val : m_st) & 8'h18);
        else if (stat_upd_en) m_st = stat_upd_val;
        for (int i = 0; i < 3; i++) begin
            if (wb && e == 5'(5 + i)) m_prt[i] = wr_data;
            else if (prt_ld_en[i]) m_prt[i] = prt_ld_val[i*8 +: 8];
        end
        if (wb && e >= 5'd8) m_gp[e] = wr_data;
        if (wb && e == 5'd4) m_ptr = wr_data;
    endtask

    task automatic idle();
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        tmr_upd_en = 0; pcl_upd_en = 0; stat_upd_en = 0;
        tmr_upd_val = 0; pcl_upd_val = 0; stat_upd_val = 0;
        prt_ld_en = 0; prt_ld_val = 0;
    endtask

    task automatic step(input string tag);
        #2;
        chk(tag, rd_data, m_read(rd_addr));
        chk("R4 tmr", tmr_q, m_tmr);
        chk("R4 pcl", pcl_q, m_pcl);
        chk("R7 stat", stat_q, m_st);
        chk("R2 ptr", ptr_q, m_ptr);
        chk("R4 ports", prt_q, {m_prt[2], m_prt[1], m_prt[0]});
        @(posedge clk);
        m_commit();
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        idle(); wr_en = 1; wr_addr = a; wr_data = d;
        step("R1 write");
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        idle(); rd_addr = a;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        m_reset();
        // R8 reset values
        chk("R8 tmr", tmr_q, 8'h00);
        chk("R8 stat", stat_q, 8'h18);
        chk("R8 ptr", ptr_q, 8'h00);
        chk("R8 ports", prt_q, 24'h0);
        chk("R8 nc stat", stat_q_nc, 8'h18);

        // R1 general storage, old value until the edge
        idle(); wr_en = 1; wr_addr = 5'h1F; wr_data = 8'hA5; rd_addr = 5'h1F;
        #2; chk("R1 old value", rd_data, 8'h00);
        step("R1 same cycle");
        rd(5'h1F, "R1 readback");
        chk("R1 literal", rd_data, 8'hA5);

        // R2 indirect through low five pointer bits
        wr(5'h04, 8'hE9);
        wr(5'h00, 8'h3C);
        idle(); rd_addr = 5'h09; #2;
        chk("R2 indirect lands at 09h", rd_data, 8'h3C);
        step("R2 read");
        rd(5'h00, "R2 indirect read");

        // R3 null location
        wr(5'h04, 8'h20);
        idle(); wr_en = 1; wr_addr = 5'h00; wr_data = 8'h77; rd_addr = 5'h00;
        #2; chk("R3 null reads zero", rd_data, 8'h00);
        step("R3 null write");
        chk("R3 pointer untouched", ptr_q, 8'h20);
        rd(5'h00, "R3 null read");

        // R5 / R6 program counter byte
        idle(); wr_en = 1; wr_addr = 5'h02; wr_data = 8'h40;
        pcl_upd_en = 1; pcl_upd_val = 8'h11;
        step("R6 pcl collide");
        chk("R6 bus wins pcl", pcl_q, 8'h40);
        chk("R5 branch byte", pcl_q, 8'h40);

        // R10 owner loads
        idle(); tmr_upd_en = 1; tmr_upd_val = 8'h5E; prt_ld_en = 3'b010; prt_ld_val = 24'h00C300;
        step("R10 load");
        chk("R10 timer load", tmr_q, 8'h5E);
        chk("R10 port B load", prt_q[15:8], 8'hC3);

        // R7 status read-only bits
        wr(5'h03, 8'h00);
        chk("R7 ro bits kept", stat_q, 8'h18);
        idle(); wr_en = 1; wr_addr = 5'h03; wr_data = 8'hFF; stat_upd_en = 1; stat_upd_val = 8'h08;
        step("R7 collide");
        chk("R7 ro from owner", stat_q, 8'hEF);

        // R4 port bytes through the bus
        wr(5'h05, 8'h81);
        rd(5'h05, "R4 port A read");
        chk("R4 port A out", prt_q[7:0], 8'h81);

        // R9 build without port C
        wr(5'h07, 8'h5A);
        idle(); rd_addr = 5'h07; prt_ld_en = 3'b100; prt_ld_val = 24'h990000; #2;
        chk("R9 07h is storage", rd_data_nc, 8'h5A);
        chk("R9 port C absent", prt_q_nc[23:16], 8'h00);
        step("R9 load");
        idle(); rd_addr = 5'h07; #2;
        chk("R9 load ignored", rd_data_nc, 8'h5A);
        chk("R4 port C loaded", rd_data, 8'h99);
        step("R9 read");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            idle();
            wr_en   = ($urandom_range(0, 3) != 0);
            wr_addr = ($urandom_range(0, 7) == 0) ? 5'd4 : 5'($urandom_range(0, 31));
            wr_data = 8'($urandom);
            rd_addr = 5'($urandom_range(0, 31));
            tmr_upd_en = ($urandom_range(0, 3) == 0); tmr_upd_val = 8'($urandom);
            pcl_upd_en = ($urandom_range(0, 3) == 0); pcl_upd_val = 8'($urandom);
            stat_upd_en = ($urandom_range(0, 5) == 0); stat_upd_val = 8'($urandom);
            prt_ld_en = 3'($urandom); prt_ld_val = 24'($urandom);
            if (rd_addr == 5'd0 && m_ptr[4:0] == 5'd0) step("R3 random");
            else if (rd_addr == 5'd0) step("R2 random");
            else step("R1 random");
        end

        rst = 1; idle();
        @(posedge clk); @(negedge clk);
        rst = 0; m_reset();
        #2;
        chk("R8 re-reset stat", stat_q, 8'h18);
        chk("R8 re-reset pcl", pcl_q, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule